// File: doc/BRIEF.md
# Card-Bus Clock Divider with Power-of-Two Select

This block derives the clock for a card bus from the peripheral clock. Software writes a 32-bit control word. A 4-bit select field in that word picks a divide ratio that is a power of two, from 2 to 512. One bit of the word gates the output on or off.

The divided clock always has equal high and low phases. The block also gives a one-cycle enable pulse at every rising edge of the divided clock, for logic that stays in the peripheral clock domain.

A typical sequence runs card identification at the divide-by-256 setting, a few hundred kHz. The clock is then moved to divide-by-4, about 20 MHz, for data transfer. A build-time parameter decides whether one extra select code passes the peripheral clock through undivided.

A ratio change is held back until the divided clock finishes a low phase, so no runt pulse appears. A select code with no defined meaning leaves the running ratio unchanged.

Top module: `card_clk_div`

## Requirements
- R1: After reset, rd_data is 0, card_clk is low and ce_pulse is low.
- R2: rd_data returns all 32 bits of the last word written with wr_en, and it does not change while wr_en is low.
- R3: With bit 24 set and select code k in bits [19:16], for k from 0 to 8, card_clk stays high for 2^k peripheral cycles and then low for 2^k cycles. This gives a divide ratio of 2^(k+1).
- R4: While the clock is divided, ce_pulse is high for exactly one peripheral cycle per card_clk period. That cycle starts at the same clock edge at which card_clk rises. While bypass is running and enabled, ce_pulse is high in every cycle.
- R5: With bit 24 cleared, card_clk finishes any high phase in progress and then stays low, and ce_pulse stays low.
- R6: Select codes 9 to 14 are ignored, and the ratio in force before the write keeps running.
- R7: With BYPASS_OK = 1, select code 15 makes card_clk follow the peripheral clock while it is enabled: high in the high half of each peripheral cycle and low in the low half. With BYPASS_OK = 0, code 15 is ignored in the same way as in R6.
- R8: A new ratio takes effect only when a low phase of card_clk ends. Any high phase in progress, and the low phase after it, keep the old length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word: select code in bits [19:16], output enable in bit 24 |
| rd_data | output | 32 | Readback of the control word |
| card_clk | output | 1 | Divided clock, or the gated peripheral clock in bypass |
| ce_pulse | output | 1 | One-cycle pulse at each rising edge of card_clk |

## Verification
The hardest case to reach from the ports is a ratio change written while card_clk is in the middle of a long high phase. The low phase that follows must keep the old length, and only the next high phase may use the new one.

The stimulus starts at divide-by-512 and waits for a rising edge. Ten cycles later it writes divide-by-4. It then measures the low phase that follows and the next high phase.

Bypass support differs between builds. For that reason, a second instance built without bypass receives the same writes, which shows that code 15 is ignored there.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int REG_W    = 32;
  localparam int SEL_W    = 4;
  localparam int SEL_LSB  = 16;
  localparam int EN_BIT   = 24;
  localparam int MAX_CODE = 8;
  localparam logic [SEL_W-1:0] BYP_CODE = '1;

  function automatic logic code_ok(input logic [SEL_W-1:0] c, input bit byp_ok);
    return (c <= SEL_W'(MAX_CODE)) || (byp_ok && (c == BYP_CODE));
  endfunction
endpackage

// File: rtl/cdiv_ctrl_reg.sv
module cdiv_ctrl_reg
  import cdiv_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else if (wr_en) word_q <= wr_data;
  end

  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(word_q)); // R2
endmodule

// File: rtl/cdiv_sel_decode.sv
module cdiv_sel_decode
  import cdiv_pkg::*;
#(
  parameter bit BYPASS_OK = 1'b1
) (
  input  logic [REG_W-1:0] word,
  output logic [SEL_W-1:0] sel,
  output logic             sel_legal,
  output logic             out_en
);
  always_comb begin
    sel       = word[SEL_LSB +: SEL_W];
    out_en    = word[EN_BIT];
    sel_legal = 1'b0;
    if (sel <= SEL_W'(MAX_CODE)) sel_legal = 1'b1;
    else if (BYPASS_OK && sel == BYP_CODE) sel_legal = 1'b1;
  end
endmodule

// File: rtl/cdiv_phase_gen.sv
module cdiv_phase_gen
  import cdiv_pkg::*;
#(
  parameter bit BYPASS_OK = 1'b1,
  parameter int CNT_W     = MAX_CODE + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             sel_legal,
  input  logic             out_en,
  output logic             div_q,
  output logic             pulse_q,
  output logic             byp_run
);
  logic [SEL_W-1:0] pend_q, act_q;
  logic [CNT_W-1:0] cnt_q, half_m1;
  logic             term, act_byp, pend_byp;

  always_comb begin
    act_byp  = BYPASS_OK && (act_q == BYP_CODE);
    pend_byp = BYPASS_OK && (pend_q == BYP_CODE);
    half_m1  = (CNT_W'(1) << act_q) - CNT_W'(1);
    term     = (cnt_q == half_m1);
    byp_run  = act_byp && out_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      act_q   <= '0;
      cnt_q   <= '0;
      div_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (sel_legal) pend_q <= sel;
      pulse_q <= 1'b0;
      if (act_byp) begin
        cnt_q   <= '0;
        div_q   <= 1'b0;
        pulse_q <= out_en;
        if (!pend_byp) act_q <= pend_q;
      end else if (term) begin
        cnt_q <= '0;
        if (div_q) begin
          div_q <= 1'b0;
        end else begin
          act_q <= pend_q;
          if (!pend_byp) begin
            div_q   <= out_en;
            pulse_q <= out_en;
          end
        end
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  always_comb begin
    if (!rst) AST_ACT_LEGAL: assert (code_ok(act_q, BYPASS_OK)); // R6
  end

  AST_OFF_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
    (!out_en && !div_q) |=> !div_q); // R5

  AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(div_q) |-> pulse_q); // R4

  AST_SWAP_IN_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> !$past(div_q)); // R8
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
  import cdiv_pkg::*;
#(
  parameter bit BYPASS_OK = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             card_clk,
  output logic             ce_pulse
);
  logic [REG_W-1:0] word_q;
  logic [SEL_W-1:0] sel;
  logic             sel_legal, out_en, div_q, byp_run;

  cdiv_ctrl_reg #(.W(REG_W)) reg_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .word_q(word_q));

  cdiv_sel_decode #(.BYPASS_OK(BYPASS_OK)) dec_i (
    .word(word_q), .sel(sel), .sel_legal(sel_legal), .out_en(out_en));

  cdiv_phase_gen #(.BYPASS_OK(BYPASS_OK)) gen_i (
    .clk(clk), .rst(rst), .sel(sel), .sel_legal(sel_legal), .out_en(out_en),
    .div_q(div_q), .pulse_q(ce_pulse), .byp_run(byp_run));

  assign rd_data = word_q;

  generate
    if (BYPASS_OK) begin : g_byp
      logic gate_q;
      always_ff @(negedge clk) begin
        if (rst) gate_q <= 1'b0;
        else gate_q <= byp_run;
      end
      assign card_clk = div_q | (clk & gate_q);
    end else begin : g_nobyp
      assign card_clk = div_q;
    end
  endgenerate

  AST_RESET_LOW: assert property (@(posedge clk)
    $past(rst) |-> (!div_q && !ce_pulse && rd_data == '0)); // R1
endmodule

// File: tb/card_clk_div_tb_top.sv
module card_clk_div_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd0, rd1;
  logic cc0, cc1, p0, p1;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  card_clk_div #(.BYPASS_OK(1'b1)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd0), .card_clk(cc0), .ce_pulse(p0));
  card_clk_div #(.BYPASS_OK(1'b0)) dut_nb_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd1), .card_clk(cc1), .ce_pulse(p1));

  localparam int NV = 9;
  localparam logic [3:0] VCODE [NV] = '{0,1,2,3,4,5,6,7,8};
  localparam int         VHALF [NV] = '{1,2,4,8,16,32,64,128,256};

  function automatic logic smp(input int w); return w ? cc1 : cc0; endfunction
  function automatic int   pls(input int w); return w ? int'(p1) : int'(p0); endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic measure(input int w, output int hi, output int lo, output int np);
    int g = 0;
    hi = 0; lo = 0; np = 0;
    do begin @(negedge clk); g++; end while (smp(w) && g < 3000);
    do begin @(negedge clk); g++; end while (!smp(w) && g < 3000);
    while (smp(w) && g < 6000) begin hi++; np += pls(w); @(negedge clk); g++; end
    while (!smp(w) && g < 6000) begin lo++; np += pls(w); @(negedge clk); g++; end
  endtask

  initial begin
    #(CLK_P*200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi, lo, np, c;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rd_data", int'(rd0), 0);
    chk("R1 card_clk", int'(cc0), 0);
    chk("R1 ce_pulse", int'(p0), 0);

    for (int i = 0; i < NV; i++) begin
      v = 32'hA100_2FFF | (32'(VCODE[i]) << 16);
      wr(v);
      chk("R2 readback", int'(rd0 == v), 1);
      measure(0, hi, lo, np);
      measure(0, hi, lo, np);
      chk("R3 high phase", hi, VHALF[i]);
      chk("R3 low phase", lo, VHALF[i]);
      chk("R4 pulses per period", np, 1);
    end

    // R6: illegal codes keep ratio /8
    wr(32'h0102_0000);
    measure(0, hi, lo, np); measure(0, hi, lo, np);
    for (int k = 9; k < 15; k++) begin
      wr(32'h0100_0000 | (32'(k) << 16));
      measure(0, hi, lo, np); measure(0, hi, lo, np);
      chk("R6 illegal code high", hi, 4);
      chk("R6 illegal code low", lo, 4);
    end

    // R7: bypass from /4
    wr(32'h0101_0000);
    measure(1, hi, lo, np);
    wr(32'h010F_0000);
    repeat (20) @(negedge clk);
    c = 0;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #(CLK_P/4);
      c += int'(cc0) + int'(p0);
      @(negedge clk); #1;
      c += int'(!cc0);
    end
    chk("R7 bypass follows clk", c, 24);
    chk("R4 bypass pulse", int'(p0), 1);
    measure(1, hi, lo, np); measure(1, hi, lo, np);
    chk("R7 no-bypass build keeps ratio", hi + lo, 4);
    wr(32'h0101_0000);
    measure(0, hi, lo, np); measure(0, hi, lo, np);
    chk("R7 leave bypass high", hi, 2);
    chk("R7 leave bypass low", lo, 2);

    // R8: change /512 -> /4 in mid high phase
    wr(32'h0108_0000);
    measure(0, hi, lo, np); measure(0, hi, lo, np);
    while (!cc0) @(negedge clk);
    repeat (10) @(negedge clk);
    wr(32'h0101_0000);
    while (cc0) @(negedge clk);
    lo = 0; while (!cc0) begin lo++; @(negedge clk); end
    hi = 0; while (cc0)  begin hi++; @(negedge clk); end
    chk("R8 low keeps old length", lo, 256);
    chk("R8 next high uses new", hi, 2);

    // R5: disable
    wr(32'h0001_0000);
    repeat (10) @(negedge clk);
    c = 0;
    for (int k = 0; k < 1200; k++) begin
      @(negedge clk); c += int'(cc0) + int'(p0) + int'(cc1) + int'(p1);
    end
    chk("R5 disabled output low", c, 0);
    wr(32'h010F_0000);
    repeat (10) @(negedge clk);
    wr(32'h000F_0000);
    repeat (10) @(negedge clk);
    c = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #(CLK_P/4); c += int'(cc0) + int'(p0);
    end
    chk("R5 bypass disabled low", c, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule